// File: doc/BRIEF.md
# Per-Bank Refresh Controller with Activate-Window Accounting

This block sits on the controller side of a low-power DRAM channel with several banks. It refreshes the device one bank at a time. While one bank is being refreshed, the other banks stay open to normal traffic. A free-running interval timer adds one unit of refresh debt per period. Each single-bank refresh pays one unit back. The banks are visited in a fixed rotating order. If the debt reaches a configured limit, the block stops issuing single-bank refreshes and asks for one refresh of the whole device instead, which clears the debt.

A single-bank refresh draws current much like a row activation, so it is charged against the same rolling four-event window as activates. The block tracks that window. It gives the main scheduler one permit line that says whether an activate may go out this cycle. It also publishes a busy vector that marks which banks may not be addressed. Refresh commands are offered on a request/grant pair: the request, the all-bank flag and the target bank are stable for a whole cycle, and the command counts as issued at the clock edge where request and grant are both high.

Top module: `pbr_ctrl`

## Requirements
- R1: After reset, no refresh is requested, the busy vector is all zero, the activate permit is high and the target bank is 0.
- R2: The first single-bank request appears only after one full refresh interval has elapsed since reset, and it targets bank 0.
- R3: The target bank advances by one on every issued single-bank refresh and wraps from the last bank to bank 0. An all-bank refresh does not move it.
- R4: An issued single-bank refresh to bank b makes busy bit b (and no other bit) high for exactly T_RFC_PB cycles, starting in the cycle after the issuing edge.
- R5: A single-bank refresh is not requested while the target bank has an open row (its `bank_open` bit is 1).
- R6: Once four events (activates or single-bank refreshes) have been issued within T_FAW cycles, the activate permit and any single-bank request stay low until the oldest of them is T_FAW cycles old.
- R7: An issued single-bank refresh takes one of the four window slots, exactly as an activate does.
- R8: When the debt reaches DEBT_LIMIT, only an all-bank request (`ref_all`=1) may be raised, and only while every `bank_open` bit is 0.
- R9: An issued all-bank refresh holds every busy bit high for T_RFC_AB cycles, and the activate permit is low during that time.
- R10: No refresh of either kind is requested while any busy bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bank_open | input | NUM_BANKS | Bit b is high while bank b holds an open row |
| act_issue | input | 1 | Scheduler issued an activate this cycle (only when `act_ok`) |
| ref_gnt | input | 1 | Command bus grants the offered refresh at this edge |
| ref_req | output | 1 | A refresh command is offered |
| ref_all | output | 1 | 1: the offer is an all-bank refresh; 0: a single-bank refresh |
| ref_bank | output | clog2(NUM_BANKS) | Target bank of the next single-bank refresh |
| bank_busy | output | NUM_BANKS | Banks that may not be addressed because of refresh |
| act_ok | output | 1 | An activate may be issued this cycle |

## Verification
The bench goes after the window boundary. It fills the window with four back-to-back activates and expects the permit back in exactly the cycle T_FAW after the first one. A window that is off by one reopens a cycle early or a cycle late. It also mixes three activates with one refresh, which a design that does not charge refreshes to the window would let through. Rotation is followed past the wrap point, where a wrong pointer would repeat or skip a bank. A closed-row precondition is held off and then released, and a design that ignored it would refresh an open bank. Debt is built up to the limit with one bank left open, to show that the all-bank fallback waits for every bank to close and then blanks the whole busy vector and the permit for its full duration.

// File: rtl/pbr_pkg.sv
package pbr_pkg;
  typedef enum logic [1:0] {
    RQ_NONE = 2'd0,
    RQ_BANK = 2'd1,
    RQ_ALL  = 2'd2
  } rq_kind_e;
endpackage

// File: rtl/pbr_faw_window.sv
// Rolling window of SLOTS recent events; each slot counts down its remaining age.
module pbr_faw_window #(
  parameter int SLOTS  = 4,
  parameter int WINDOW = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic event_i,
  output logic room_o
);
  localparam int CW = $clog2(WINDOW + 1);

  logic [SLOTS-1:0] free;
  logic [SLOTS-1:0] pick;

  always_comb begin
    logic found;
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (free[i] && !found) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [CW-1:0] age_q, age_d;
    assign free[g] = (age_q == '0);

    always_comb begin
      age_d = age_q;
      if (event_i && pick[g])  age_d = CW'(WINDOW - 1);
      else if (!free[g])       age_d = age_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) age_q <= '0;
      else        age_q <= age_d;
    end
  end

  assign room_o = |free;
endmodule

// File: rtl/pbr_busy_timers.sv
// One refresh-occupancy countdown per bank.
module pbr_busy_timers #(
  parameter int NB   = 8,
  parameter int T_PB = 45,
  parameter int T_AB = 105
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] pb_load_i,
  input  logic          ab_load_i,
  output logic [NB-1:0] busy_o,
  output logic          ab_active_o
);
  localparam int TMAX = (T_AB > T_PB) ? T_AB : T_PB;
  localparam int TW   = $clog2(TMAX + 1);

  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic [TW-1:0] cnt_q, cnt_d;

    always_comb begin
      cnt_d = cnt_q;
      if (ab_load_i)          cnt_d = TW'(T_AB);
      else if (pb_load_i[g])  cnt_d = TW'(T_PB);
      else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end

    assign busy_o[g] = (cnt_q != '0);
  end

  assign ab_active_o = &busy_o;
endmodule

// File: rtl/pbr_debt.sv
// Interval timer and owed-refresh counter.
module pbr_debt #(
  parameter int REFI  = 488,
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pb_done_i,
  input  logic ab_done_i,
  output logic owed_any_o,
  output logic urgent_o
);
  localparam int IW = $clog2(REFI);
  localparam int OW = $clog2(LIMIT + 1);

  logic [IW-1:0] ivl_q, ivl_d;
  logic [OW-1:0] owed_q, owed_d;
  logic          tick;

  assign tick = (ivl_q == IW'(REFI - 1));

  always_comb begin
    ivl_d = tick ? '0 : ivl_q + 1'b1;
    if (ab_done_i) begin
      owed_d = tick ? OW'(1) : '0;
    end else begin
      owed_d = owed_q;
      if (tick && owed_q != OW'(LIMIT)) owed_d = owed_d + 1'b1;
      if (pb_done_i)                    owed_d = owed_d - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl_q  <= '0;
      owed_q <= '0;
    end else begin
      ivl_q  <= ivl_d;
      owed_q <= owed_d;
    end
  end

  assign owed_any_o = (owed_q != '0);
  assign urgent_o   = (owed_q == OW'(LIMIT));
endmodule

// File: rtl/pbr_ctrl.sv
module pbr_ctrl
  import pbr_pkg::*;
#(
  parameter int NUM_BANKS  = 8,
  parameter int REFI_PB    = 488,
  parameter int T_RFC_PB   = 45,
  parameter int T_RFC_AB   = 105,
  parameter int T_FAW      = 25,
  parameter int FAW_SLOTS  = 4,
  parameter int DEBT_LIMIT = 8,
  localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] bank_open,
  input  logic                 act_issue,
  input  logic                 ref_gnt,
  output logic                 ref_req,
  output logic                 ref_all,
  output logic [BW-1:0]        ref_bank,
  output logic [NUM_BANKS-1:0] bank_busy,
  output logic                 act_ok
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  logic [BW-1:0]        ptr_q, ptr_d;
  logic [NUM_BANKS-1:0] busy;
  logic [NUM_BANKS-1:0] pb_load;
  logic                 ab_active, faw_room, owed_any, owed_urgent;
  logic                 fire, pb_fire, ab_fire;
  rq_kind_e             rq;

  always_comb begin
    rq = RQ_NONE;
    if (!(|busy)) begin
      if (owed_urgent) begin
        if (bank_open == '0) rq = RQ_ALL;
      end else if (owed_any && !bank_open[ptr_q] && faw_room) begin
        rq = RQ_BANK;
      end
    end
  end

  assign fire    = (rq != RQ_NONE) && ref_gnt;
  assign pb_fire = fire && (rq == RQ_BANK);
  assign ab_fire = fire && (rq == RQ_ALL);
  assign pb_load = pb_fire ? (NUM_BANKS'(1) << ptr_q) : '0;

  always_comb begin
    ptr_d = ptr_q;
    if (pb_fire) ptr_d = (ptr_q == BW'(NUM_BANKS - 1)) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) ptr_q <= '0;
    else             ptr_q <= ptr_d;
  end

  pbr_debt #(.REFI(REFI_PB), .LIMIT(DEBT_LIMIT)) u_debt (
    .clk(clk), .rst_n(rst_core_n), .pb_done_i(pb_fire), .ab_done_i(ab_fire),
    .owed_any_o(owed_any), .urgent_o(owed_urgent)
  );

  pbr_faw_window #(.SLOTS(FAW_SLOTS), .WINDOW(T_FAW)) u_faw (
    .clk(clk), .rst_n(rst_core_n), .event_i(act_issue | pb_fire), .room_o(faw_room)
  );

  pbr_busy_timers #(.NB(NUM_BANKS), .T_PB(T_RFC_PB), .T_AB(T_RFC_AB)) u_busy (
    .clk(clk), .rst_n(rst_core_n), .pb_load_i(pb_load), .ab_load_i(ab_fire),
    .busy_o(busy), .ab_active_o(ab_active)
  );

  assign ref_req   = (rq != RQ_NONE);
  assign ref_all   = (rq == RQ_ALL);
  assign ref_bank  = ptr_q;
  assign bank_busy = busy;
  assign act_ok    = faw_room && !ab_active;
endmodule

// File: rtl/pbr_ctrl_chk.sv
module pbr_ctrl_chk #(
  parameter int NB = 8,
  parameter int BW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NB-1:0] bank_open,
  input logic          act_issue,
  input logic          ref_gnt,
  input logic          ref_req,
  input logic          ref_all,
  input logic [BW-1:0] ref_bank,
  input logic [NB-1:0] bank_busy,
  input logic          act_ok
);
  AST_NO_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> (bank_busy == '0)); // R10

  AST_PB_TARGET_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_all) |-> !bank_open[ref_bank]); // R5

  AST_AB_ALL_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_all) |-> (bank_open == '0)); // R8

  AST_PTR_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_gnt && !ref_all) |=>
      (ref_bank == (($past(ref_bank) == BW'(NB - 1)) ? '0 : BW'($past(ref_bank) + 1'b1)))); // R3

  AST_PB_SINGLE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_gnt && !ref_all) |=> (bank_busy == (NB'(1) << $past(ref_bank)))); // R4

  AST_BUSY_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_busy) || (&bank_busy)); // R4

  AST_AB_BLOCKS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    (&bank_busy) |-> !act_ok); // R9

  AST_ACT_PERMITTED: assert property (@(posedge clk) disable iff (!rst_n)
    act_issue |-> act_ok); // R6
endmodule

bind pbr_ctrl pbr_ctrl_chk #(.NB(NUM_BANKS), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bank_open(bank_open), .act_issue(act_issue),
  .ref_gnt(ref_gnt), .ref_req(ref_req), .ref_all(ref_all), .ref_bank(ref_bank),
  .bank_busy(bank_busy), .act_ok(act_ok)
);

// File: tb/sim_pbr_ctrl.sv
`timescale 1ns/1ps
module sim_pbr_ctrl;
  localparam int NB    = 8;
  localparam int REFI  = 40;
  localparam int T_PB  = 6;
  localparam int T_AB  = 14;
  localparam int T_FAW = 16;
  localparam int LIM   = 5;

  logic          clk, rst_n;
  logic [NB-1:0] bank_open;
  logic          act_issue, ref_gnt;
  logic          ref_req, ref_all;
  logic [2:0]    ref_bank;
  logic [NB-1:0] bank_busy;
  logic          act_ok;

  int errors = 0;
  int checks = 0;
  int exp_ptr = 0;
  logic [3:0] exp_q[$];

  pbr_ctrl #(.NUM_BANKS(NB), .REFI_PB(REFI), .T_RFC_PB(T_PB), .T_RFC_AB(T_AB),
             .T_FAW(T_FAW), .FAW_SLOTS(4), .DEBT_LIMIT(LIM)) u0 (
    .clk(clk), .rst_n(rst_n), .bank_open(bank_open), .act_issue(act_issue),
    .ref_gnt(ref_gnt), .ref_req(ref_req), .ref_all(ref_all), .ref_bank(ref_bank),
    .bank_busy(bank_busy), .act_ok(act_ok));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // driver side of the scoreboard
  task automatic expect_ref(input bit all, input int bank);
    exp_q.push_back({all, 3'(bank)});
  endtask

  // monitor: refresh commands and the busy vector
  int          mcnt = 0;
  logic [NB-1:0] mmask = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mcnt > 0 || bank_busy != '0)
        check(bank_busy == (mcnt > 0 ? mmask : '0), "R4/R9 busy vector",
              int'(bank_busy), int'(mcnt > 0 ? mmask : '0));
      if (mcnt > 0) mcnt--;
      if (ref_req && ref_gnt) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected refresh", int'({ref_all, ref_bank}), -1);
        end else begin
          logic [3:0] e;
          e = exp_q.pop_front();
          check(ref_all == e[3], "R8 refresh kind", int'(ref_all), int'(e[3]));
          if (!e[3]) check(ref_bank == e[2:0], "R3 target bank", int'(ref_bank), int'(e[2:0]));
        end
        mcnt  = ref_all ? T_AB : T_PB;
        mmask = ref_all ? '1 : (NB'(1) << ref_bank);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    summary();
    $finish;
  end

  task automatic wait_req(input string req);
    bit seen;
    seen = 1'b0;
    for (int n = 0; n < 300; n++) begin
      @(negedge clk);
      if (ref_req) begin seen = 1'b1; break; end
    end
    check(seen, req, 0, 1);
  endtask

  task automatic grant_one();
    @(posedge clk); #1 ref_gnt = 1'b1;
    @(posedge clk); #1 ref_gnt = 1'b0;
  endtask

  task automatic grant_pb();
    expect_ref(1'b0, exp_ptr);
    grant_one();
    exp_ptr = (exp_ptr + 1) % NB;
  endtask

  task automatic drain();
    for (int i = 0; i < 10; i++) begin
      repeat (T_PB + 2) @(negedge clk);
      if (ref_req && !ref_all) grant_pb();
      else break;
    end
  endtask

  task automatic acts(input int n);
    @(posedge clk); #1 act_issue = 1'b1;
    repeat (n) @(posedge clk);
    #1 act_issue = 1'b0;
  endtask

  initial begin
    int n;
    rst_n = 1'b0; bank_open = '0; act_issue = 1'b0; ref_gnt = 1'b0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    check(ref_req == 1'b0, "R1 ref_req", int'(ref_req), 0);
    check(bank_busy == '0, "R1 bank_busy", int'(bank_busy), 0);
    check(act_ok == 1'b1, "R1 act_ok", int'(act_ok), 1);
    check(ref_bank == 3'd0, "R1 ref_bank", int'(ref_bank), 0);

    // R2 first request after one interval
    n = 0;
    while (!ref_req && n < 100) begin @(negedge clk); n++; end
    check(n >= 40 && n <= 46, "R2 first request cycle", n + 1, 44);
    check(ref_bank == 3'd0 && !ref_all, "R2 first target", int'(ref_bank), 0);
    grant_pb();

    // R3 R4 rotation through all banks and past the wrap
    for (int i = 0; i < 8; i++) begin
      wait_req("R3 request arrives");
      grant_pb();
    end
    check(ref_bank == 3'(exp_ptr), "R3 pointer after wrap", int'(ref_bank), exp_ptr);

    // R10 debt of two: second request held while the first bank is busy
    repeat (82) @(negedge clk);
    wait_req("R10 request with debt");
    grant_pb();
    for (int k = 0; k < T_PB; k++) begin
      @(negedge clk);
      check(ref_req == 1'b0, "R10 no request while busy", int'(ref_req), 0);
      @(posedge clk);
    end
    @(negedge clk);
    check(ref_req == 1'b1, "R10 request after busy ends", int'(ref_req), 1);
    grant_pb();
    drain();

    // R5 open target bank holds the request
    @(posedge clk); #1 bank_open = NB'(1) << exp_ptr;
    repeat (45) @(negedge clk);
    check(ref_req == 1'b0, "R5 held while target open", int'(ref_req), 0);
    @(posedge clk); #1 bank_open = '0;
    @(negedge clk);
    check(ref_req == 1'b1 && ref_bank == 3'(exp_ptr), "R5 released", int'(ref_req), 1);
    grant_pb();
    drain();

    // R6 four activates fill the window; exact reopening cycle
    wait_req("R6 pending refresh");
    acts(4);
    @(negedge clk);
    check(act_ok == 1'b0, "R6 permit low after four", int'(act_ok), 0);
    check(ref_req == 1'b0, "R6 refresh blocked by window", int'(ref_req), 0);
    for (int j = 4; j <= T_FAW - 2; j++) begin
      @(posedge clk); @(negedge clk);
      check(act_ok == 1'b0, "R6 permit still low", int'(act_ok), 0);
    end
    @(posedge clk); @(negedge clk);
    check(act_ok == 1'b1, "R6 permit back at window end", int'(act_ok), 1);
    check(ref_req == 1'b1, "R6 refresh back at window end", int'(ref_req), 1);
    grant_pb();

    // R7 three activates plus one refresh fill the window
    wait_req("R7 pending refresh");
    repeat (T_FAW + 2) @(negedge clk);
    acts(3);
    @(negedge clk);
    check(act_ok == 1'b1, "R7 one slot left", int'(act_ok), 1);
    check(ref_req == 1'b1, "R7 refresh allowed into last slot", int'(ref_req), 1);
    grant_pb();
    @(negedge clk);
    check(act_ok == 1'b0, "R7 refresh used the last slot", int'(act_ok), 0);
    repeat (T_FAW + 2) @(negedge clk);
    drain();

    // R8 R9 debt to the limit with one bank open
    @(posedge clk); #1 bank_open = 8'h01;
    repeat (240) @(negedge clk);
    check(ref_req == 1'b0, "R8 all-bank waits for closed banks", int'(ref_req), 0);
    @(posedge clk); #1 bank_open = '0;
    @(negedge clk);
    check(ref_req && ref_all, "R8 all-bank request", int'({ref_req, ref_all}), 3);
    expect_ref(1'b1, 0);
    grant_one();
    repeat (T_AB / 2) @(negedge clk);
    check(act_ok == 1'b0, "R9 permit low during all-bank", int'(act_ok), 0);
    check(bank_busy == '1, "R9 all banks busy", int'(bank_busy), 255);
    check(ref_req == 1'b0, "R10 no request during all-bank", int'(ref_req), 0);
    repeat (T_AB) @(negedge clk);
    check(bank_busy == '0, "R9 busy cleared", int'(bank_busy), 0);
    check(exp_q.size() == 0, "R3 all expected refreshes seen", exp_q.size(), 0);

    summary();
    $finish;
  end
endmodule